// File: doc/BRIEF.md
# Card Clock Divider Selector

This block produces the clock that drives one smart card, derived from an external input clock. A 2-bit ratio select picks one of four settings: the input divided by 8, 4 or 2, or the input passed straight through. A free-running 3-bit phase counter on the input clock supplies the divided waveforms. A new ratio is taken up only when the counter wraps from 7 to 0. At that point every divided waveform ends a high phase and begins a low phase, so a change of ratio never leaves a short pulse on the card.

A power-down request parks the card clock at a programmable level, high or low. The block waits until the output reaches that level on its own, then holds it there. While the clock is parked, the input clock may be stopped. It must be running again before the request is released. On release, counting resumes from the frozen counter value, which sits at the start of the parked phase, so the first phase after release is never short. An enable from the activation logic clears the counter and holds the card clock low while it is deasserted.

Top module: `cclk_gen`

## Requirements
- R1: Select code 0 yields the input clock divided by 8, code 1 divided by 4, code 2 divided by 2, and code 3 the input clock itself. In the divided settings the high and low phases are equal.
- R2: A new select code is adopted only at the counter step from 7 to 0. No output phase is shorter than 45% of the smaller of the old and the new period.
- R3: A select change sampled on an input clock rising edge is in effect within 8 input clock cycles. The next full output period has the new length.
- R4: With power-down asserted and the park level input at 1, the card clock settles high within 9 input cycles and stays high while power-down remains asserted.
- R5: With power-down asserted and the park level input at 0, the card clock settles low within 9 input cycles and stays low while power-down remains asserted.
- R6: While the clock is parked, the input clock may be halted without changing the output. After the input clock restarts and power-down is released, the output resumes with the period of the current select code.
- R7: While enable is 0, the card clock is held low whatever the select, power-down and park level inputs are, and the phase counter is cleared. After enable returns to 1, the output runs at the selected ratio.
- R8: The synchronous active-high reset drives the card clock low, including in the middle of pass-through operation.
- R9: In pass-through (code 3), the card clock is high while the input clock is high and low while it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock from which the card clock is derived |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enable from the activation logic; 0 holds the output low |
| ratio_sel_i | input | 2 | Ratio select: 0 = /8, 1 = /4, 2 = /2, 3 = pass-through |
| pwr_down_i | input | 1 | Request to park the card clock |
| park_high_i | input | 1 | Park level: 1 = high, 0 = low |
| card_clk_o | output | 1 | Clock driven to the card |

## Verification
A select change is sampled on the next input clock rising edge and adopted at the following counter wrap, which is at most 8 cycles later. The bench therefore waits 10 cycles before it times one full output period from a card clock rising edge.

A park request settles within 9 cycles. The bench samples the parked level after 20 cycles and then re-samples it in both halves of each later input cycle. Enable and reset take effect after one rising edge and one falling edge of the input clock, and the bench samples 2 to 3 cycles later.

Throughout the run, a monitor times every high and low phase against 45% of the smaller period of the settings in play.

// File: rtl/cclk_pkg.sv
package cclk_pkg;

    // Number of binary divider stages; the pass-through code sits above them.
    localparam int DIV_STAGES = 3;
    localparam int SEL_W      = $clog2(DIV_STAGES + 1);

    typedef logic [DIV_STAGES-1:0] phase_t;
    typedef logic [SEL_W-1:0]      ratio_t;

    localparam ratio_t RATIO_PASS = ratio_t'(DIV_STAGES);
    localparam phase_t PHASE_LAST = '1;

    // Registered controller state.
    typedef struct packed {
        logic   run;   // 0 while the output is parked
        logic   en;    // registered enable
        ratio_t sel;   // ratio in effect
        logic   lvl;   // divided-path output level
    } ctl_t;

    // Per-cycle decision of the controller.
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_HOLD,
        ACT_WAKE,
        ACT_PARK,
        ACT_RUN
    } act_e;

    // Output level of a divided setting at a given counter phase.
    // Code k uses counter bit DIV_STAGES-1-k; the pass-through code yields 0.
    function automatic logic level_at(ratio_t sel, phase_t ph);
        logic l;
        l = 1'b0;
        for (int b = 0; b < DIV_STAGES; b++) begin
            if (int'(sel) == DIV_STAGES - 1 - b) l = ph[b];
        end
        return l;
    endfunction

endpackage

// File: rtl/cclk_phase_cnt.sv
module cclk_phase_cnt
    import cclk_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   clear_i,
    input  logic   step_i,
    output phase_t cnt_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            cnt_o <= '0;
        end else if (step_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/cclk_ratio_ctrl.sv
module cclk_ratio_ctrl
    import cclk_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   en_i,
    input  ratio_t sel_i,
    input  logic   pd_i,
    input  logic   park_hi_i,
    input  phase_t cnt_i,
    output logic   step_o,
    output logic   clear_o,
    output logic   div_o,
    output logic   pass_o
);

    ctl_t   st_q, st_d;
    act_e   act;
    phase_t ph_nx;
    logic   lvl_keep;
    logic   park_ok;

    assign ph_nx    = cnt_i + 1'b1;
    assign lvl_keep = level_at(st_q.sel, ph_nx);
    // Park in pass-through at any rising edge; in divided settings only on
    // an edge of the output into the requested level.
    assign park_ok  = (st_q.sel == RATIO_PASS) ||
                      ((lvl_keep == park_hi_i) && (st_q.lvl != park_hi_i));

    always_comb begin
        if (!en_i)                 act = ACT_IDLE;
        else if (!st_q.run)        act = pd_i ? ACT_HOLD : ACT_WAKE;
        else if (pd_i && park_ok)  act = ACT_PARK;
        else                       act = ACT_RUN;
    end

    always_comb begin
        st_d    = st_q;
        st_d.en = en_i;
        case (act)
            ACT_IDLE: begin
                st_d.run = 1'b1;
                st_d.lvl = 1'b0;
                st_d.sel = sel_i;
            end
            ACT_HOLD: begin
                st_d.run = 1'b0;
            end
            ACT_WAKE: begin
                st_d.run = 1'b1;
                if (st_q.sel == RATIO_PASS) st_d.lvl = 1'b0;
            end
            ACT_PARK: begin
                st_d.run = 1'b0;
                st_d.lvl = park_hi_i;
            end
            default: begin
                if (ph_nx == '0) st_d.sel = sel_i;
                st_d.lvl = level_at(st_d.sel, ph_nx);
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{run: 1'b1, en: 1'b0, sel: '0, lvl: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o  = en_i && st_q.run;
    assign clear_o = !en_i;
    assign div_o   = st_q.lvl;
    assign pass_o  = st_q.run && st_q.en && (st_q.sel == RATIO_PASS);

    // R2
    sel_at_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.sel != $past(st_q.sel)) |-> (($past(cnt_i) == PHASE_LAST) || !$past(en_i)));

    // R6
    park_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.run && !$past(st_q.run)) |-> ($stable(cnt_i) && $stable(st_q.lvl)));

    // R4 R5
    park_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.run && $past(st_q.run)) |-> (st_q.lvl == $past(park_hi_i)));

    // R7
    idle_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> ((cnt_i == '0) && !st_q.lvl && st_q.run));

endmodule

// File: rtl/cclk_out_stage.sv
module cclk_out_stage (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pass_req_i,
    input  logic div_i,
    output logic card_clk_o
);

    logic pass_q;

    // The pass-through gate only opens or closes while the input clock is low.
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            pass_q <= 1'b0;
        end else begin
            pass_q <= pass_req_i;
        end
    end

    assign card_clk_o = (pass_q & clk_i) | div_i;

    // R2
    pass_entry_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        $rose(pass_q) |-> !$past(div_i));

endmodule

// File: rtl/cclk_gen.sv
module cclk_gen
    import cclk_pkg::*;
(
    input  logic             clk_in,
    input  logic             rst,
    input  logic             en_i,
    input  logic [SEL_W-1:0] ratio_sel_i,
    input  logic             pwr_down_i,
    input  logic             park_high_i,
    output logic             card_clk_o
);

    phase_t cnt;
    logic   step, clear, div_lvl, pass_req;

    cclk_phase_cnt u_cnt (
        .clk_i   (clk_in),
        .rst_i   (rst),
        .clear_i (clear),
        .step_i  (step),
        .cnt_o   (cnt)
    );

    cclk_ratio_ctrl u_ctrl (
        .clk_i     (clk_in),
        .rst_i     (rst),
        .en_i      (en_i),
        .sel_i     (ratio_t'(ratio_sel_i)),
        .pd_i      (pwr_down_i),
        .park_hi_i (park_high_i),
        .cnt_i     (cnt),
        .step_o    (step),
        .clear_o   (clear),
        .div_o     (div_lvl),
        .pass_o    (pass_req)
    );

    cclk_out_stage u_out (
        .clk_i      (clk_in),
        .rst_i      (rst),
        .pass_req_i (pass_req),
        .div_i      (div_lvl),
        .card_clk_o (card_clk_o)
    );

endmodule

// File: tb/test_cclk_gen.sv
`timescale 1ns/1ps
module test_cclk_gen;

    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst, en, pd, hi;
    logic [1:0] sel;
    logic       card_clk;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int       cur = 0;
    realtime  lim = 0.0;
    bit       mon_on = 0;
    bit       have_last = 0;
    realtime  last_edge = 0.0;

    localparam int NVEC = 15;
    localparam int VEC_SEL  [NVEC] = '{0, 1, 2, 3, 0, 2, 3, 1, 0, 3, 2, 1, 3, 2, 0};
    localparam int VEC_HALF [NVEC] = '{80, 40, 20, 10, 80, 20, 10, 40, 80, 10, 20, 40, 10, 20, 80};

    always #10 if (clk_run) clk = ~clk;

    cclk_gen i_cclk_gen (
        .clk_in      (clk),
        .rst         (rst),
        .en_i        (en),
        .ratio_sel_i (sel),
        .pwr_down_i  (pd),
        .park_high_i (hi),
        .card_clk_o  (card_clk)
    );

    function automatic realtime per_ns(int c);
        return (c == 3) ? 20.0 : 20.0 * real'(1 << (3 - c));
    endfunction

    task automatic chk_bit(string tag, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_time(string tag, realtime act, realtime exp);
        tests++;
        if (act < exp - 0.5 || act > exp + 0.5) begin
            fails++;
            $display("FAIL %s: got %0.2f ns expected %0.2f ns", tag, act, exp);
        end
    endtask

    // R2: every completed phase is timed against the current limit.
    always @(card_clk) begin
        if (mon_on && have_last) begin
            tests++;
            if ($realtime - last_edge < lim - 0.01) begin
                fails++;
                $display("FAIL R2: phase %0.2f ns expected at least %0.2f ns",
                         $realtime - last_edge, lim);
            end
        end
        last_edge = $realtime;
        have_last = 1;
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic set_sel(int c);
        realtime a, b;
        a = per_ns(cur);
        b = per_ns(c);
        lim = 0.45 * ((a < b) ? a : b);
        sel = 2'(c);
        cur = c;
    endtask

    task automatic measure(output realtime h, output realtime l);
        realtime t0, t1, t2;
        @(posedge card_clk); t0 = $realtime;
        @(negedge card_clk); t1 = $realtime;
        @(posedge card_clk); t2 = $realtime;
        h = t1 - t0;
        l = t2 - t1;
        wait_cyc(1);
    endtask

    // Counts samples in both halves of n input cycles that differ from v.
    task automatic count_off(int n, logic v, output int bad);
        bad = 0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #5;
            if (card_clk !== v) bad++;
            #10;
            if (card_clk !== v) bad++;
        end
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        realtime h, l;
        int bad;
        rst = 1'b1; en = 1'b0; pd = 1'b0; hi = 1'b0; sel = 2'd0;

        // R8 reset state
        wait_cyc(3);
        chk_bit("R8 output during reset", card_clk, 1'b0);
        rst = 1'b0;
        wait_cyc(1);
        chk_bit("R8 output after reset", card_clk, 1'b0);

        // R1 default ratio after enable
        en = 1'b1;
        lim = 0.45 * per_ns(0);
        wait_cyc(10);
        mon_on = 1;
        measure(h, l);
        chk_time("R1 div8 high", h, 80.0);
        chk_time("R1 div8 low", l, 80.0);

        // R1 R3 vector table over all ratio transitions
        for (int i = 0; i < NVEC; i++) begin
            set_sel(VEC_SEL[i]);
            wait_cyc(10);
            measure(h, l);
            chk_time($sformatf("R1 R3 vec%0d high", i), h, real'(VEC_HALF[i]));
            chk_time($sformatf("R1 R3 vec%0d low", i), l, real'(VEC_HALF[i]));
            lim = 0.45 * per_ns(cur);
        end

        // R9 pass-through follows the input clock
        set_sel(3);
        wait_cyc(10);
        lim = 0.45 * per_ns(3);
        bad = 0;
        for (int k = 0; k < 16; k++) begin
            @(posedge clk); #5;
            if (card_clk !== 1'b1) bad++;
            #10;
            if (card_clk !== 1'b0) bad++;
        end
        chk_int("R9 pass-through mismatches", bad, 0);

        // R4 R5 R6 parking for every ratio and both levels
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 2; v++) begin
                set_sel(c);
                wait_cyc(10);
                lim = 0.45 * per_ns(c);
                hi = 1'(v);
                pd = 1'b1;
                wait_cyc(20);
                chk_bit($sformatf("%s parked level code %0d", v ? "R4" : "R5", c),
                        card_clk, 1'(v));
                count_off(20, 1'(v), bad);
                chk_int($sformatf("%s parked hold code %0d", v ? "R4" : "R5", c), bad, 0);
                if ((c == 0 && v == 1) || (c == 3 && v == 0)) begin
                    #6 clk_run = 1'b0;
                    #400;
                    chk_bit($sformatf("R6 halted input code %0d", c), card_clk, 1'(v));
                    clk_run = 1'b1;
                    wait_cyc(3);
                    chk_bit($sformatf("R6 restarted input code %0d", c), card_clk, 1'(v));
                end
                pd = 1'b0;
                wait_cyc(12);
                measure(h, l);
                chk_time($sformatf("R6 resumed period code %0d", c), h + l, per_ns(c));
            end
        end

        // R7 enable low holds output low regardless of other inputs
        set_sel(3);
        wait_cyc(10);
        mon_on = 0;
        en = 1'b0; pd = 1'b1; hi = 1'b1;
        wait_cyc(3);
        count_off(20, 1'b0, bad);
        chk_int("R7 held low while disabled", bad, 0);
        set_sel(1);
        count_off(10, 1'b0, bad);
        chk_int("R7 select ignored while disabled", bad, 0);
        pd = 1'b0;
        en = 1'b1;
        wait_cyc(12);
        lim = 0.45 * per_ns(1);
        mon_on = 1;
        measure(h, l);
        chk_time("R7 period after enable", h + l, per_ns(1));

        // R8 reset in the middle of pass-through
        set_sel(3);
        wait_cyc(10);
        mon_on = 0;
        rst = 1'b1;
        wait_cyc(2);
        count_off(4, 1'b0, bad);
        chk_int("R8 output low under mid-run reset", bad, 0);
        rst = 1'b0;
        wait_cyc(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule